// File: doc/BRIEF.md
# Oscillator Frequency Configuration Register Bank

This block is the settings store for a programmable clock oscillator. Software or a bus bridge reaches it through a simple synchronous register port with an 8-bit address, write data, a write strobe, a read strobe and read data. The block keeps a 10-bit fine tuning code, a coarse window select, a divider exponent with a dither select, and a small device-select field. It also has a factory trim value that software can only read, and a command address that asks for the settings to be saved to nonvolatile storage.

The block turns the coarse and fine settings into one master frequency code in units of 10 kHz. The coarse select is measured against the trim value and picks a window 10.24 MHz wide. Each window starts 5.12 MHz above the one below it. The fine code then adds 10 kHz per step inside that window. The divider exponent, the dither select and the fine code also go straight out to the oscillator core.

Top module: `osc_cfg_regbank`

## Requirements
- R1: A synchronous reset sets these values: coarse select equal to the trim value's 5 LSBs (OS), fine code 0, divider exponent 0, dither select 0, device select 0, read data 0, store request 0 and frequency code 9216.
- R2: The fine code is 10 bits. A write to 08h loads code bits 9..2. A write to 09h loads code bits 1..0 from data bits 7..6. The `dac_code` output shows the new value after the write edge. A read of 09h returns code bits 1..0 in bits 7..6 and zeros in the other bits.
- R3: A write to 0Eh treats the whole data byte as an unsigned number and stores it clamped to the range OS-6 to OS+6. A read of 0Eh returns the stored value with the upper bits zero.
- R4: `freq_10k` equals 6144 + (coarse - (OS-6)) * 512 + fine. It is registered, so it follows a register change one clock later.
- R5: A write to 02h sets the dither select from data bit 4 and the divider exponent from bits 3..0. An exponent above 8 is stored as 8. A read returns {3'b0, dither, exponent}.
- R6: Address 37h always reads as the trim value (default EFh). Writes to 37h change no register and no output.
- R7: A write to 3Fh raises `nv_store_req` for exactly the one cycle after the write edge and changes no register. Address 3Fh reads as zero.
- R8: `reg_rdata` loads on the edge where `reg_rd` is sampled high, holds its value while `reg_rd` is low, and returns zero for addresses outside the map.
- R9: A write to 0Dh stores data bits 3..0 as the device select. A read returns them with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| pre_exp | output | 4 | Divider exponent, 0 to 8 |
| dither_sel | output | 1 | Dither depth select |
| dac_code | output | 10 | Fine tuning code |
| freq_10k | output | 14 | Master frequency code in 10 kHz units |
| nv_store_req | output | 1 | One-cycle request to save the settings |

## Verification
The hardest cases are the corners where the clamp and the split fine code meet. Examples are a coarse value far above the byte range that must land exactly on OS+6, a fine code assembled from two separate byte writes, and the largest frequency code 13311. Random byte writes almost never hit the clamp edges in a useful order, so directed writes first put the bank at both window ends and at the all-ones fine code. Random writes and reads over the mapped addresses then mix with a few unmapped ones, and each result is checked against a bench model of the register bank.

// File: rtl/osc_cfg_pkg.sv
package osc_cfg_pkg;

  localparam int BUS_W = 8;

  localparam logic [BUS_W-1:0] A_PRESC   = 8'h02;
  localparam logic [BUS_W-1:0] A_DAC_HI  = 8'h08;
  localparam logic [BUS_W-1:0] A_DAC_LO  = 8'h09;
  localparam logic [BUS_W-1:0] A_DEVSEL  = 8'h0D;
  localparam logic [BUS_W-1:0] A_OFFSET  = 8'h0E;
  localparam logic [BUS_W-1:0] A_RANGE   = 8'h37;
  localparam logic [BUS_W-1:0] A_NVSTORE = 8'h3F;

  // write slots: one strobe per writable address
  typedef enum int {
    W_PRESC   = 0,
    W_DAC_HI  = 1,
    W_DAC_LO  = 2,
    W_DEVSEL  = 3,
    W_OFFSET  = 4,
    W_NVSTORE = 5
  } wr_slot_e;

  localparam int N_WSLOT = 6;

  function automatic logic [BUS_W-1:0] slot_addr(input int s);
    case (s)
      W_PRESC:   return A_PRESC;
      W_DAC_HI:  return A_DAC_HI;
      W_DAC_LO:  return A_DAC_LO;
      W_DEVSEL:  return A_DEVSEL;
      W_OFFSET:  return A_OFFSET;
      default:   return A_NVSTORE;
    endcase
  endfunction

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // coarse window start plus fine step, all in 10 kHz units
  function automatic int freq_code(input int ofs, input int dac, input int os,
                                   input int span, input int base, input int step);
    return base + (ofs - (os - span)) * step + dac;
  endfunction

endpackage

// File: rtl/osc_cfg_wdec.sv
module osc_cfg_wdec
  import osc_cfg_pkg::*;
(
  input  logic               wr,
  input  logic [BUS_W-1:0]   addr,
  output logic [N_WSLOT-1:0] hit
);

  for (genvar s = 0; s < N_WSLOT; s++) begin : g_slot
    assign hit[s] = wr && (addr == slot_addr(s));
  end

endmodule

// File: rtl/osc_cfg_regs.sv
module osc_cfg_regs
  import osc_cfg_pkg::*;
#(
  parameter int DAC_W    = 10,
  parameter int OFS_W    = 5,
  parameter int EXP_W    = 4,
  parameter int EXP_MAX  = 8,
  parameter int DEV_W    = 4,
  parameter int OS       = 15,
  parameter int OFS_SPAN = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_WSLOT-1:0] hit,
  input  logic [BUS_W-1:0]   wdata,
  output logic [DAC_W-1:0]   dac_q,
  output logic [OFS_W-1:0]   ofs_q,
  output logic [EXP_W-1:0]   exp_q,
  output logic               dith_q,
  output logic [DEV_W-1:0]   dev_q,
  output logic               nv_q
);

  localparam int LO_BITS = DAC_W - BUS_W;
  localparam int OFS_LO  = OS - OFS_SPAN;
  localparam int OFS_HI  = OS + OFS_SPAN;

  logic [EXP_W-1:0] exp_wr;
  logic [OFS_W-1:0] ofs_wr;

  assign exp_wr = (int'(wdata[EXP_W-1:0]) > EXP_MAX) ? EXP_W'(EXP_MAX)
                                                    : wdata[EXP_W-1:0];
  assign ofs_wr = OFS_W'(clamp_int(int'(wdata), OFS_LO, OFS_HI));

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_q  <= '0;
      ofs_q  <= OFS_W'(OS);
      exp_q  <= '0;
      dith_q <= 1'b0;
      dev_q  <= '0;
      nv_q   <= 1'b0;
    end else begin
      nv_q <= hit[W_NVSTORE];
      if (hit[W_PRESC]) begin
        exp_q  <= exp_wr;
        dith_q <= wdata[EXP_W];
      end
      if (hit[W_DAC_HI]) dac_q[DAC_W-1 -: BUS_W] <= wdata;
      if (hit[W_DAC_LO]) dac_q[LO_BITS-1:0] <= wdata[BUS_W-1 -: LO_BITS];
      if (hit[W_DEVSEL]) dev_q <= wdata[DEV_W-1:0];
      if (hit[W_OFFSET]) ofs_q <= ofs_wr;
    end
  end

endmodule

// File: rtl/osc_cfg_freq.sv
module osc_cfg_freq
  import osc_cfg_pkg::*;
#(
  parameter int DAC_W    = 10,
  parameter int OFS_W    = 5,
  parameter int FREQ_W   = 14,
  parameter int OS       = 15,
  parameter int OFS_SPAN = 6,
  parameter int BASE     = 6144,
  parameter int STEP     = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DAC_W-1:0]  dac,
  output logic [FREQ_W-1:0] freq_next,
  output logic [FREQ_W-1:0] freq_q
);

  localparam int FREQ_RST = BASE + OFS_SPAN * STEP;

  assign freq_next = FREQ_W'(freq_code(int'(ofs), int'(dac), OS, OFS_SPAN, BASE, STEP));

  always_ff @(posedge clk) begin
    if (rst) freq_q <= FREQ_W'(FREQ_RST);
    else     freq_q <= freq_next;
  end

endmodule

// File: rtl/osc_cfg_regbank.sv
module osc_cfg_regbank
  import osc_cfg_pkg::*;
#(
  parameter logic [7:0] RANGE_INIT = 8'hEF,
  parameter int DAC_W    = 10,
  parameter int OFS_W    = 5,
  parameter int EXP_W    = 4,
  parameter int EXP_MAX  = 8,
  parameter int DEV_W    = 4,
  parameter int OFS_SPAN = 6,
  parameter int BASE_10K = 6144,
  parameter int WIN_STEP = 512,
  localparam int OS      = int'(RANGE_INIT[OFS_W-1:0]),
  localparam int FREQ_W  = $clog2(BASE_10K + 2 * OFS_SPAN * WIN_STEP + (1 << DAC_W))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  output logic [EXP_W-1:0]  pre_exp,
  output logic              dither_sel,
  output logic [DAC_W-1:0]  dac_code,
  output logic [FREQ_W-1:0] freq_10k,
  output logic              nv_store_req
);

  localparam int LO_BITS = DAC_W - BUS_W;

  logic [N_WSLOT-1:0] wr_hit;
  logic [DAC_W-1:0]   dac_q;
  logic [OFS_W-1:0]   ofs_val;
  logic [EXP_W-1:0]   exp_q;
  logic               dith_q;
  logic [DEV_W-1:0]   dev_q;
  logic               nv_q;
  logic [FREQ_W-1:0]  freq_next;
  logic [FREQ_W-1:0]  freq_q;
  logic [BUS_W-1:0]   rd_mux;
  logic [BUS_W-1:0]   rdata_q;

  osc_cfg_wdec wdec_i (
    .wr   (reg_wr),
    .addr (reg_addr),
    .hit  (wr_hit)
  );

  osc_cfg_regs #(
    .DAC_W(DAC_W), .OFS_W(OFS_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX),
    .DEV_W(DEV_W), .OS(OS), .OFS_SPAN(OFS_SPAN)
  ) regs_i (
    .clk    (clk),
    .rst    (rst),
    .hit    (wr_hit),
    .wdata  (reg_wdata),
    .dac_q  (dac_q),
    .ofs_q  (ofs_val),
    .exp_q  (exp_q),
    .dith_q (dith_q),
    .dev_q  (dev_q),
    .nv_q   (nv_q)
  );

  osc_cfg_freq #(
    .DAC_W(DAC_W), .OFS_W(OFS_W), .FREQ_W(FREQ_W), .OS(OS),
    .OFS_SPAN(OFS_SPAN), .BASE(BASE_10K), .STEP(WIN_STEP)
  ) freq_i (
    .clk       (clk),
    .rst       (rst),
    .ofs       (ofs_val),
    .dac       (dac_q),
    .freq_next (freq_next),
    .freq_q    (freq_q)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_PRESC:  rd_mux = BUS_W'({dith_q, exp_q});
      A_DAC_HI: rd_mux = dac_q[DAC_W-1 -: BUS_W];
      A_DAC_LO: rd_mux = {dac_q[LO_BITS-1:0], {(BUS_W-LO_BITS){1'b0}}};
      A_DEVSEL: rd_mux = BUS_W'(dev_q);
      A_OFFSET: rd_mux = BUS_W'(ofs_val);
      A_RANGE:  rd_mux = RANGE_INIT;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata    = rdata_q;
  assign pre_exp      = exp_q;
  assign dither_sel   = dith_q;
  assign dac_code     = dac_q;
  assign freq_10k     = freq_q;
  assign nv_store_req = nv_q;

endmodule

// File: rtl/osc_cfg_chk.sv
module osc_cfg_chk
  import osc_cfg_pkg::*;
#(
  parameter logic [7:0] RANGE_INIT = 8'hEF,
  parameter int DAC_W    = 10,
  parameter int OFS_W    = 5,
  parameter int EXP_W    = 4,
  parameter int EXP_MAX  = 8,
  parameter int OFS_SPAN = 6,
  parameter int BASE_10K = 6144,
  parameter int WIN_STEP = 512,
  parameter int FREQ_W   = 14
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [7:0]        reg_rdata,
  input logic [EXP_W-1:0]  pre_exp,
  input logic [DAC_W-1:0]  dac_code,
  input logic [FREQ_W-1:0] freq_10k,
  input logic              nv_store_req,
  input logic [OFS_W-1:0]  ofs_val
);

  localparam int OS     = int'(RANGE_INIT[OFS_W-1:0]);
  localparam int F_MAX  = BASE_10K + 2 * OFS_SPAN * WIN_STEP + (1 << DAC_W) - 1;

  // R3
  ofs_window_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(ofs_val) >= OS - OFS_SPAN) && (int'(ofs_val) <= OS + OFS_SPAN));

  // R5
  exp_limit_chk: assert property (@(posedge clk) disable iff (rst)
    int'(pre_exp) <= EXP_MAX);

  // R7
  nv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_NVSTORE) |=> nv_store_req);

  // R7
  nv_cause_chk: assert property (@(posedge clk) disable iff (rst)
    nv_store_req |-> $past(reg_wr && reg_addr == A_NVSTORE));

  // R2
  dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && (reg_addr == A_DAC_HI || reg_addr == A_DAC_LO)) |=> $stable(dac_code));

  // R6
  range_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_RANGE) |=> reg_rdata == RANGE_INIT);

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));

  // R4
  freq_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(freq_10k) >= BASE_10K) && (int'(freq_10k) <= F_MAX));

  // R4
  freq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(dac_code) && $stable(ofs_val)) |=> $stable(freq_10k));

endmodule

bind osc_cfg_regbank osc_cfg_chk #(
  .RANGE_INIT(RANGE_INIT), .DAC_W(DAC_W), .OFS_W(OFS_W), .EXP_W(EXP_W),
  .EXP_MAX(EXP_MAX), .OFS_SPAN(OFS_SPAN), .BASE_10K(BASE_10K),
  .WIN_STEP(WIN_STEP), .FREQ_W(FREQ_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .reg_addr     (reg_addr),
  .reg_wr       (reg_wr),
  .reg_rd       (reg_rd),
  .reg_rdata    (reg_rdata),
  .pre_exp      (pre_exp),
  .dac_code     (dac_code),
  .freq_10k     (freq_10k),
  .nv_store_req (nv_store_req),
  .ofs_val      (ofs_val)
);

// File: tb/osc_cfg_regbank_tb_top.sv
module osc_cfg_regbank_tb_top;

  localparam int TRIM = 'hEF;
  localparam int OSV  = 15;
  localparam int OLO  = OSV - 6;
  localparam int OHI  = OSV + 6;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic        reg_wr;
  logic        reg_rd;
  logic [7:0]  reg_rdata;
  logic [3:0]  pre_exp;
  logic        dither_sel;
  logic [9:0]  dac_code;
  logic [13:0] freq_10k;
  logic        nv_store_req;

  always #4 clk = ~clk;

  osc_cfg_regbank dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .pre_exp(pre_exp), .dither_sel(dither_sel), .dac_code(dac_code),
    .freq_10k(freq_10k), .nv_store_req(nv_store_req)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int m_ofs, m_dac, m_exp, m_dith, m_dev;

  function automatic int exp_freq();
    return 6144 + (m_ofs - OLO) * 512 + m_dac;
  endfunction

  function automatic int model_read(input int a);
    case (a)
      'h02: return m_dith * 16 + m_exp;
      'h08: return m_dac >> 2;
      'h09: return (m_dac % 4) * 64;
      'h0D: return m_dev;
      'h0E: return m_ofs;
      'h37: return TRIM;
      default: return 0;
    endcase
  endfunction

  function automatic void model_write(input int a, input int d);
    case (a)
      'h02: begin m_exp = (d % 16 > 8) ? 8 : d % 16; m_dith = (d / 16) % 2; end
      'h08: m_dac = d * 4 + m_dac % 4;
      'h09: m_dac = (m_dac / 4) * 4 + d / 64;
      'h0D: m_dev = d % 16;
      'h0E: m_ofs = (d < OLO) ? OLO : ((d > OHI) ? OHI : d);
      default: ;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic check_outs();
    chk("R2 dac_code", 32'(dac_code), expv_i(m_dac));
    chk("R5 pre_exp", 32'(pre_exp), expv_i(m_exp));
    chk("R5 dither_sel", 32'(dither_sel), expv_i(m_dith));
    chk("R4 freq_10k", 32'(freq_10k), expv_i(exp_freq()));
    chk("R7 idle nv_store_req", 32'(nv_store_req), 32'd0);
  endtask

  function automatic logic [31:0] expv_i(input int v);
    return 32'(v);
  endfunction

  task automatic do_write(input int a, input int d);
    @(negedge clk);
    reg_addr = 8'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R7 store pulse", 32'(nv_store_req), (a == 'h3F) ? 32'd1 : 32'd0);
    model_write(a, d);
    @(negedge clk);
    check_outs();
  endtask

  task automatic do_read(input int a);
    logic [7:0] got;
    @(negedge clk);
    reg_addr = 8'(a); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    got = reg_rdata;
    case (a)
      'h02:    chk("R5 read", 32'(got), expv_i(model_read(a)));
      'h08, 'h09: chk("R2 read", 32'(got), expv_i(model_read(a)));
      'h0D:    chk("R9 read", 32'(got), expv_i(model_read(a)));
      'h0E:    chk("R3 read", 32'(got), expv_i(model_read(a)));
      'h37:    chk("R6 read", 32'(got), expv_i(model_read(a)));
      'h3F:    chk("R7 read", 32'(got), 32'd0);
      default: chk("R8 unmapped read", 32'(got), 32'd0);
    endcase
    reg_addr = 8'h08;
    @(negedge clk);
    chk("R8 hold", 32'(reg_rdata), 32'(got));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int addrs[9];
    void'($urandom(32'd20240611));
    addrs = '{'h02, 'h08, 'h09, 'h0D, 'h0E, 'h37, 'h3F, 'h10, 'hFF};
    rst = 1'b1; reg_addr = '0; reg_wdata = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    m_ofs = OSV; m_dac = 0; m_exp = 0; m_dith = 0; m_dev = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 freq", 32'(freq_10k), 32'd9216);
    chk("R1 dac", 32'(dac_code), 32'd0);
    chk("R1 exp", 32'(pre_exp), 32'd0);
    chk("R1 dither", 32'(dither_sel), 32'd0);
    chk("R1 rdata", 32'(reg_rdata), 32'd0);
    chk("R1 nv", 32'(nv_store_req), 32'd0);
    do_read('h0E);
    chk("R1 offset default", 32'(reg_rdata), 32'(OSV));

    // R2 split fine code, top of window, R4 max code
    do_write('h08, 'hFF);
    do_write('h09, 'hFF);
    do_read('h09);
    do_write('h0E, 'hFF);
    chk("R4 max freq", 32'(freq_10k), 32'd13311);
    // R3 clamp at both ends
    do_write('h0E, 0);
    do_read('h0E);
    do_write('h0E, OHI + 1);
    do_write('h0E, OLO);
    do_write('h0E, OHI);
    do_read('h0E);
    // R5 exponent clamp and dither bit
    do_write('h02, 'h1F);
    do_read('h02);
    do_write('h02, 'hE8);
    do_write('h02, 'h09);
    // R6 range write ignored
    do_write('h37, 'h00);
    do_read('h37);
    // R7 store command leaves registers alone
    do_write('h3F, 'h55);
    do_read('h3F);
    do_read('h0E);
    // R9 device select
    do_write('h0D, 'hAB);
    do_read('h0D);
    // R8 unmapped
    do_read('h10);

    for (int i = 0; i < 400; i++) begin
      int a;
      int d;
      a = addrs[$urandom_range(8)];
      d = int'($urandom_range(255));
      if ($urandom_range(1) == 0) do_write(a, d);
      else                        do_read(a);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule